// File: doc/BRIEF.md
# Fusable Six-Lane Event Counter Bank

This block holds six event counters laid out as three neighbouring pairs (0/1, 2/3, 4/5). Each counter owns a configuration word and a count word, both reached through one register read/write port. Each counter also receives a small increment from its event source every clock. On its own, a counter is 48 bits wide and advances by at most 15 per cycle.

Some events can happen more often than fifteen times per cycle. For these, an odd counter can be given a reserved merge code. It then gives up its own counting and lends its increment lane and its low count bits to the even counter below it. The pair then behaves as one 64-bit counter that adds an 8-bit increment every cycle. Software reads the fused value through the even counter. The top 16 bits are loaded by writing the odd counter.

Top module: `evc_bank`

## Requirements
- R1: After a synchronous active-low reset, every configuration word and every count reads zero, and no overflow bit is set.
- R2: A counter whose configuration bit 16 (enable) is 1 adds its 4-bit increment lane (evt_inc[4c+3:4c] for counter c) every cycle. A counter whose enable bit is 0 holds its value.
- R3: An unmerged counter is 48 bits wide and counts independently of its neighbour. On wrap past 2^48-1 it keeps the value modulo 2^48, and its overflow bit ovf[c] is high for exactly the one cycle in which the wrapped value first appears.
- R4: Pair p is made of counters 2p and 2p+1. The pair is merged while the odd counter's configuration has bits [11:0] equal to 0xFFF and bit 16 equal to 1.
- R5: While merged, the pair value {odd[15:0], even[47:0]} advances by the 8-bit increment {odd lane, even lane} each cycle in which the even counter is enabled. The odd counter does not count on its own.
- R6: Reading the even count of a merged pair returns the full 64-bit value. Any unmerged count reads as its 48 bits zero-extended to 64.
- R7: A write to an even count loads only its 48 bits. In merged mode the upper 16 bits of the pair are left unchanged.
- R8: A write to an odd count loads its 48-bit register. While merged, the low 16 bits of that register are the pair's upper 16 bits.
- R9: Writing 0xFFF with the enable bit into an even counter's configuration has no merging effect. Both counters of that pair keep counting on their own.
- R10: A merged pair wraps modulo 2^64. Its overflow is signalled on ovf[2p] only, and ovf[2p+1] stays low while merged.
- R11: A register write takes effect at the next clock edge. A count write beats the same-cycle increment of that counter, and in merged mode a count write to either half suspends that cycle's pair increment. The mode for a cycle comes from the configuration held before that cycle's edge.
- R12: When the odd configuration stops matching the merge setting, the odd counter resumes independent 48-bit counting from its current 48-bit register.
- R13: reg_addr[3:1] selects the counter and reg_addr[0] selects the word (0 = configuration, 1 = count). A configuration reads back as its 32 bits zero-extended. Indices 6 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Counter index [3:1] and word select [0] |
| reg_wdata | input | 48 | Write data (configuration uses bits [31:0]) |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| evt_inc | input | 24 | Six 4-bit per-cycle increment lanes |
| ovf | output | 6 | One-cycle overflow pulse per counter |

## Verification
The bench targets the carry across the 48-bit seam into the odd counter's low 16 bits. A design that got this wrong would read back a 64-bit value stuck below 2^48, or would pulse the overflow at 2^48 instead of 2^64. It checks that an even-count write in merged mode spares the upper bits, and that a write on the same edge as an increment leaves exactly the written value; a design that got either wrong would drop the upper bits or add a stray increment. It also places the merge code on an even counter and later clears it on an odd one. A faulty design would fuse the wrong pair in the first case. In the second it would keep hiding the odd counter, or restart it from zero rather than from its retained bits.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the event counter bank: lane widths, count widths,
// configuration field positions and the register address split.
package evc_pkg;
    localparam int NUM_PAIRS  = 3;
    localparam int NUM_CNT    = 2 * NUM_PAIRS;
    localparam int INC_W      = 4;
    localparam int CNT_W      = 48;
    localparam int WIDE_W     = 64;
    localparam int HI_W       = WIDE_W - CNT_W;
    localparam int CFG_W      = 32;
    localparam int EV_W       = 12;
    localparam int EN_BIT     = 16;
    localparam logic [EV_W-1:0] MERGE_CODE = 12'hFFF;
    localparam int IDX_W      = $clog2(NUM_CNT);
    localparam int ADDR_W     = IDX_W + 1;
endpackage

// File: rtl/evc_pair.sv
`timescale 1ns/1ps
// One even/odd counter pair. Each counter works alone at CNT_W bits unless
// the odd configuration carries the merge code with its enable bit; then the
// pair forms a WIDE_W counter fed by both lanes.
// Assumes at most one write strobe (cfg_we/cnt_we bits) is high per cycle.
module evc_pair #(
    parameter int INC_W  = evc_pkg::INC_W,
    parameter int CNT_W  = evc_pkg::CNT_W,
    parameter int WIDE_W = evc_pkg::WIDE_W,
    parameter int CFG_W  = evc_pkg::CFG_W,
    parameter int EV_W   = evc_pkg::EV_W,
    parameter int EN_BIT = evc_pkg::EN_BIT,
    parameter logic [EV_W-1:0] MERGE_CODE = evc_pkg::MERGE_CODE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_we,
    input  logic [1:0]           cnt_we,
    input  logic [CNT_W-1:0]     wdata,
    input  logic [2*INC_W-1:0]   inc,
    output logic [CFG_W-1:0]     cfg_e_rd,
    output logic [CFG_W-1:0]     cfg_o_rd,
    output logic [WIDE_W-1:0]    cnt_e_rd,
    output logic [WIDE_W-1:0]    cnt_o_rd,
    output logic [1:0]           ovf
);
    localparam int HI_W = WIDE_W - CNT_W;

    logic [CFG_W-1:0]  cfg_e, cfg_o;
    logic [CNT_W-1:0]  cnt_e, cnt_o;
    logic [1:0]        ovf_q;
    logic              merged;
    logic [CNT_W:0]    e_sum, o_sum;
    logic [WIDE_W:0]   wide_sum;

    // Merge decode from the odd configuration word.
    assign merged = (cfg_o[EV_W-1:0] == MERGE_CODE) && cfg_o[EN_BIT];

    // Candidate next values for the independent and fused modes.
    always_comb begin
        e_sum    = {1'b0, cnt_e} + {{(CNT_W+1-INC_W){1'b0}}, inc[INC_W-1:0]};
        o_sum    = {1'b0, cnt_o} + {{(CNT_W+1-INC_W){1'b0}}, inc[2*INC_W-1:INC_W]};
        wide_sum = {1'b0, cnt_o[HI_W-1:0], cnt_e}
                 + {{(WIDE_W+1-2*INC_W){1'b0}}, inc[2*INC_W-1:INC_W], inc[INC_W-1:0]};
    end

    // Configuration words: plain registers loaded by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_e <= '0;
            cfg_o <= '0;
        end else begin
            if (cfg_we[0]) cfg_e <= wdata[CFG_W-1:0];
            if (cfg_we[1]) cfg_o <= wdata[CFG_W-1:0];
        end
    end

    // Count update: increment per mode, then writes override the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_e <= '0;
            cnt_o <= '0;
            ovf_q <= '0;
        end else begin
            ovf_q <= '0;
            if (merged) begin
                if (!(|cnt_we) && cfg_e[EN_BIT]) begin
                    cnt_e            <= wide_sum[CNT_W-1:0];
                    cnt_o[HI_W-1:0]  <= wide_sum[WIDE_W-1:CNT_W];
                    ovf_q[0]         <= wide_sum[WIDE_W];
                end
            end else begin
                if (!cnt_we[0] && cfg_e[EN_BIT]) begin
                    cnt_e    <= e_sum[CNT_W-1:0];
                    ovf_q[0] <= e_sum[CNT_W];
                end
                if (!cnt_we[1] && cfg_o[EN_BIT]) begin
                    cnt_o    <= o_sum[CNT_W-1:0];
                    ovf_q[1] <= o_sum[CNT_W];
                end
            end
            if (cnt_we[0]) cnt_e <= wdata;
            if (cnt_we[1]) cnt_o <= wdata;
        end
    end

    // Read views: the even count widens to the fused value while merged.
    assign cfg_e_rd = cfg_e;
    assign cfg_o_rd = cfg_o;
    assign cnt_e_rd = merged ? {cnt_o[HI_W-1:0], cnt_e} : {{HI_W{1'b0}}, cnt_e};
    assign cnt_o_rd = {{HI_W{1'b0}}, cnt_o};
    assign ovf      = ovf_q;

    // R11: a count write lands exactly, whatever the increment.
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we[0] |=> cnt_e == $past(wdata));

    // R7: an even write in merged mode leaves the upper bits alone.
    a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (merged && cnt_we[0] && !cnt_we[1]) |=> cnt_o[HI_W-1:0] == $past(cnt_o[HI_W-1:0]));

    // R2: a disabled, unwritten, unmerged even counter holds.
    a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!merged && !cfg_e[EN_BIT] && !cnt_we[0]) |=> $stable(cnt_e));

    // R10: the odd half never reports overflow while fused.
    a_r10_odd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        merged |=> !ovf_q[1]);

    // R3: right after a wrap the low count is smaller than one fused step.
    a_r3_wrap_small: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q[0] |-> cnt_e < CNT_W'(1 << (2*INC_W)));
endmodule

// File: rtl/evc_rdmux.sv
`timescale 1ns/1ps
// Read selection for the bank: picks a configuration or count word by index.
// Assumes per-counter views are already widened to WIDE_W.
module evc_rdmux #(
    parameter int NUM_CNT = evc_pkg::NUM_CNT,
    parameter int CFG_W   = evc_pkg::CFG_W,
    parameter int WIDE_W  = evc_pkg::WIDE_W,
    parameter int ADDR_W  = evc_pkg::ADDR_W
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_CNT-1:0][CFG_W-1:0]  cfg_all,
    input  logic [NUM_CNT-1:0][WIDE_W-1:0] cnt_all,
    output logic [WIDE_W-1:0]              rdata
);
    logic [ADDR_W-2:0] idx;
    assign idx = addr[ADDR_W-1:1];

    // Word select with zero for indices beyond the bank.
    always_comb begin
        rdata = '0;
        if (int'(idx) < NUM_CNT) begin
            if (addr[0]) rdata = cnt_all[idx];
            else         rdata = {{(WIDE_W-CFG_W){1'b0}}, cfg_all[idx]};
        end
    end
endmodule

// File: rtl/evc_bank.sv
`timescale 1ns/1ps
// Bank of NUM_PAIRS fusable counter pairs behind a single register port.
// Decodes writes to one pair member, gathers read views and overflow pulses.
// Assumes one register access per cycle; reads are combinational.
module evc_bank (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    reg_we,
    input  logic [evc_pkg::ADDR_W-1:0]              reg_addr,
    input  logic [evc_pkg::CNT_W-1:0]               reg_wdata,
    output logic [evc_pkg::WIDE_W-1:0]              reg_rdata,
    input  logic [evc_pkg::NUM_CNT*evc_pkg::INC_W-1:0] evt_inc,
    output logic [evc_pkg::NUM_CNT-1:0]             ovf
);
    import evc_pkg::*;

    logic [IDX_W-1:0]                wr_idx;
    logic [NUM_CNT-1:0][CFG_W-1:0]   cfg_all;
    logic [NUM_CNT-1:0][WIDE_W-1:0]  cnt_all;

    assign wr_idx = reg_addr[ADDR_W-1:1];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic [1:0] cfg_we_p, cnt_we_p;
        // Per-pair write strobes from the shared address.
        always_comb begin
            for (int k = 0; k < 2; k++) begin
                cfg_we_p[k] = reg_we && !reg_addr[0] && (int'(wr_idx) == 2*p + k);
                cnt_we_p[k] = reg_we &&  reg_addr[0] && (int'(wr_idx) == 2*p + k);
            end
        end

        evc_pair u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we_p),
            .cnt_we   (cnt_we_p),
            .wdata    (reg_wdata),
            .inc      (evt_inc[2*p*INC_W +: 2*INC_W]),
            .cfg_e_rd (cfg_all[2*p]),
            .cfg_o_rd (cfg_all[2*p+1]),
            .cnt_e_rd (cnt_all[2*p]),
            .cnt_o_rd (cnt_all[2*p+1]),
            .ovf      (ovf[2*p +: 2])
        );
    end

    evc_rdmux u_rdmux (
        .addr    (reg_addr),
        .cfg_all (cfg_all),
        .cnt_all (cnt_all),
        .rdata   (reg_rdata)
    );
endmodule

// File: tb/tb_evc_bank.sv
`timescale 1ns/1ps
module tb_evc_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [47:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [23:0] evt_inc = '0;
    logic [5:0]  ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    // Behavioural reference state.
    logic [47:0] m_cnt [6];
    logic [31:0] m_cfg [6];
    logic [5:0]  m_ovf;

    evc_bank dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
                  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_inc(evt_inc), .ovf(ovf));

    always #2 clk = ~clk;

    function automatic bit m_merged(int p);
        return m_cfg[2*p+1][11:0] == 12'hFFF && m_cfg[2*p+1][16];
    endfunction

    function automatic logic [63:0] m_read(logic [3:0] a);
        int i = int'(a[3:1]);
        if (i >= 6) return 64'd0;
        if (!a[0]) return {32'd0, m_cfg[i]};
        if (i % 2 == 0 && m_merged(i / 2)) return {m_cnt[i+1][15:0], m_cnt[i]};
        return {16'd0, m_cnt[i]};
    endfunction

    task automatic m_step(logic we, logic [3:0] a, logic [47:0] d, logic [23:0] inc);
        logic [47:0] n [6];
        logic [64:0] s65;
        logic [48:0] s49;
        for (int c = 0; c < 6; c++) n[c] = m_cnt[c];
        m_ovf = '0;
        for (int p = 0; p < 3; p++) begin
            int e = 2 * p;
            int o = 2 * p + 1;
            bit we_e = we && a[0] && int'(a[3:1]) == e;
            bit we_o = we && a[0] && int'(a[3:1]) == o;
            if (m_merged(p)) begin
                if (!we_e && !we_o && m_cfg[e][16]) begin
                    s65 = {1'b0, m_cnt[o][15:0], m_cnt[e]} + {57'd0, inc[4*o +: 4], inc[4*e +: 4]};
                    n[e] = s65[47:0];
                    n[o][15:0] = s65[63:48];
                    m_ovf[e] = s65[64];
                end
            end else begin
                if (!we_e && m_cfg[e][16]) begin
                    s49 = {1'b0, m_cnt[e]} + {45'd0, inc[4*e +: 4]};
                    n[e] = s49[47:0]; m_ovf[e] = s49[48];
                end
                if (!we_o && m_cfg[o][16]) begin
                    s49 = {1'b0, m_cnt[o]} + {45'd0, inc[4*o +: 4]};
                    n[o] = s49[47:0]; m_ovf[o] = s49[48];
                end
            end
        end
        if (we && int'(a[3:1]) < 6) begin
            if (a[0]) n[int'(a[3:1])] = d;
            else      m_cfg[int'(a[3:1])] = d[31:0];
        end
        for (int c = 0; c < 6; c++) m_cnt[c] = n[c];
    endtask

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // One clock: drive, advance the model at the edge, compare after it.
    task automatic cyc(logic we, logic [3:0] a, logic [47:0] d, logic [23:0] inc);
        reg_we = we; reg_addr = a; reg_wdata = d; evt_inc = inc;
        @(posedge clk);
        m_step(we, a, d, inc);
        #1;
        chk({cur_tag, " ovf"}, {58'd0, ovf}, {58'd0, m_ovf});
        chk({cur_tag, " rdata"}, reg_rdata, m_read(a));
    endtask

    task automatic rd(string tag, logic [3:0] a, logic [63:0] exp);
        reg_we = 0; reg_addr = a; evt_inc = '0;
        #1;
        chk(tag, reg_rdata, exp);
        chk({tag, " model"}, reg_rdata, m_read(a));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 6; c++) begin m_cnt[c] = '0; m_cfg[c] = '0; end
        m_ovf = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state of every word
        cur_tag = "R1";
        for (int a = 0; a < 16; a++) cyc(0, 4'(a), 0, 0);
        rd("R1 cnt0 zero", 4'h1, 64'd0);
        // R2: enable all counters and count independent patterns
        cur_tag = "R2";
        for (int c = 0; c < 6; c++) cyc(1, {3'(c), 1'b0}, 48'h10000, 0);
        for (int i = 0; i < 24; i++) cyc(0, {3'(i % 6), 1'b1}, 0, 24'(i * 32'h9E3779B));
        cyc(1, 4'h6, 48'h0, 0);  // disable counter 3
        for (int i = 0; i < 6; i++) cyc(0, 4'h7, 0, 24'hFFFFFF);
        cyc(1, 4'h6, 48'h10000, 0);
        // R3: 48-bit wrap of counter 2
        cur_tag = "R3";
        cyc(1, 4'h5, 48'hFFFF_FFFF_FFFD, 0);
        cyc(0, 4'h5, 0, 24'h000500);
        chk("R3 ovf2 pulse", {63'd0, ovf[2]}, 64'd1);
        rd("R3 cnt2 wrapped", 4'h5, 64'd2);
        cyc(0, 4'h5, 0, 24'h0);
        chk("R3 ovf2 one cycle", {63'd0, ovf[2]}, 64'd0);
        // R4 R5: merge pair 0 and count with the fused lane
        cur_tag = "R4";
        cyc(1, 4'h2, 48'h10FFF, 0);
        cyc(1, 4'h1, 48'h0, 0);
        cyc(1, 4'h3, 48'h0, 0);
        cur_tag = "R5";
        for (int i = 0; i < 4; i++) cyc(0, 4'h1, 0, 24'h000023);
        rd("R5 fused +0x23 x4", 4'h1, 64'h8C);
        rd("R5 odd not counting", 4'h3, 64'd0);
        // R8 R6: upper bits through the odd count, full read on the even
        cur_tag = "R8";
        cyc(1, 4'h3, 48'hABCD, 0);
        cur_tag = "R6";
        rd("R6 fused read", 4'h1, 64'hABCD_0000_0000_008C);
        // R7: even write loads low 48 bits only
        cur_tag = "R7";
        cyc(1, 4'h1, 48'h1234_5678_9ABC, 0);
        rd("R7 upper kept", 4'h1, 64'hABCD_1234_5678_9ABC);
        // R11: write beats same-cycle increment in merged mode
        cur_tag = "R11";
        cyc(1, 4'h1, 48'h40, 24'h0000FF);
        rd("R11 merged write wins", 4'h1, 64'hABCD_0000_0000_0040);
        cyc(1, 4'h9, 48'd100, 24'h090000);
        rd("R11 unmerged write wins", 4'h9, 64'd100);
        // R10: 64-bit wrap reports on even bit only
        cur_tag = "R10";
        cyc(1, 4'h1, 48'hFFFF_FFFF_FFFF, 0);
        cyc(1, 4'h3, 48'hFFFF, 0);
        cyc(0, 4'h1, 0, 24'h000012);
        chk("R10 ovf even/odd", {62'd0, ovf[1:0]}, 64'd1);
        rd("R10 fused wrapped", 4'h1, 64'h11);
        // R9: merge code on an even counter has no effect
        cur_tag = "R9";
        cyc(1, 4'h4, 48'h10FFF, 0);
        cyc(1, 4'h6, 48'h10005, 0);
        cyc(1, 4'h5, 48'h0, 0);
        cyc(1, 4'h7, 48'h0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 4'h5, 0, 24'h00FF00);
        rd("R9 cnt2 alone", 4'h5, 64'd45);
        rd("R9 cnt3 alone", 4'h7, 64'd45);
        // R12: unmerge pair 0, odd resumes from its own bits
        cur_tag = "R12";
        cyc(1, 4'h3, 48'h7, 0);
        cyc(1, 4'h2, 48'h10000, 0);
        cyc(0, 4'h3, 0, 24'h000040);
        cyc(0, 4'h3, 0, 24'h000040);
        rd("R12 odd resumes", 4'h3, 64'd15);
        rd("R12 even 48-bit view", 4'h1, 64'h11);
        // R13: address map edges
        cur_tag = "R13";
        cyc(1, 4'hC, 48'h10000, 0);
        cyc(1, 4'hD, 48'h55, 0);
        rd("R13 idx6 cfg", 4'hC, 64'd0);
        rd("R13 idx6 cnt", 4'hD, 64'd0);
        rd("R13 idx7 cnt", 4'hF, 64'd0);
        rd("R13 cfg readback", 4'h6, 64'h10005);
        for (int i = 0; i < 30; i++) cyc(0, {3'(i % 8), 1'(i % 2)}, 0, 24'(i * 32'h5A5A5));
        finish_run();
    end
endmodule